// File: doc/BRIEF.md
# Modem Handshake Line Monitor

This block handles the modem handshake side of a serial port. It drives two handshake outputs, data-terminal-ready and request-to-send, from control bits. It watches four handshake inputs: clear-to-send, data-set-ready, carrier-detect and ring-indicate. Each input goes through a two-flop synchronizer. A per-line change flag then records transitions and holds them until software reads the status byte. One interrupt line is raised while any change flag is set and the interrupt enable is on.

For clear-to-send, data-set-ready and carrier-detect, a change in either direction sets the flag. For ring-indicate, only the trailing edge sets it, that is the 1-to-0 transition when ringing stops. A loop control bit turns on self-test. In loop mode the external input pins are ignored, the four line inputs are fed from the two handshake control bits and two spare control bits, and both output pins are forced inactive. Address decoding and the register bus are outside this block: the block receives control bits as levels and a one-cycle status-read strobe.

All handshake signals are active-high at the ports. Any pin inversion is done outside the block.

Top module: `modem_hs_ctrl`

## Requirements
- R1: After reset with all input pins low, `stat_o` reads 8'h00 and `irq_o` is 0.
- R2: With `ctl_loop` low, `pin_dtr_o` equals `ctl_dtr` and `pin_rts_o` equals `ctl_rts`.
- R3: With `ctl_loop` high, `pin_dtr_o` and `pin_rts_o` are both 0, whatever the control bits are.
- R4: The line levels appear in `stat_o[7:4]`: bit 4 clear-to-send, bit 5 data-set-ready, bit 6 ring-indicate, bit 7 carrier-detect. A pin change reaches its bit after the second rising clock edge.
- R5: Any transition, rising or falling, of clear-to-send, data-set-ready or carrier-detect sets its change flag one edge after the new level shows. The flags are in `stat_o[0]`, `stat_o[1]` and `stat_o[3]`.
- R6: The ring-indicate flag `stat_o[2]` is set only by a 1-to-0 transition of ring-indicate. A 0-to-1 transition leaves it unchanged.
- R7: A rising edge with `stat_rd` high clears all four change flags. Levels and flags are visible on `stat_o` in the cycle of the read.
- R8: If a line transition would set its flag on the same edge as a read, that flag ends up set.
- R9: `irq_o` is 1 exactly when `irq_en` is 1 and at least one change flag is set.
- R10: With `ctl_loop` high, the external input pins are ignored. Clear-to-send follows `ctl_rts`, data-set-ready follows `ctl_dtr`, ring-indicate follows `ctl_aux1` and carrier-detect follows `ctl_aux2`, all through the same synchronizer.
- R11: A set change flag stays set until a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_dtr | input | 1 | Data-terminal-ready control bit |
| ctl_rts | input | 1 | Request-to-send control bit |
| ctl_aux1 | input | 1 | Spare control bit, loop source for ring-indicate |
| ctl_aux2 | input | 1 | Spare control bit, loop source for carrier-detect |
| ctl_loop | input | 1 | Self-test loop enable |
| irq_en | input | 1 | Line-change interrupt enable |
| stat_rd | input | 1 | One-cycle status-read strobe, clears flags |
| pin_cts_i | input | 1 | Clear-to-send pin |
| pin_dsr_i | input | 1 | Data-set-ready pin |
| pin_dcd_i | input | 1 | Carrier-detect pin |
| pin_ri_i | input | 1 | Ring-indicate pin |
| pin_dtr_o | output | 1 | Data-terminal-ready pin |
| pin_rts_o | output | 1 | Request-to-send pin |
| stat_o | output | 8 | Levels [7:4] and change flags [3:0] |
| irq_o | output | 1 | Line-change interrupt |

## Verification
Some properties are checked on every cycle: the interrupt agrees with the enable and the flags, the output pins obey loop mode and the control bits, a flag stays set until a read, a rising or falling clear-to-send level sets its flag on the next edge, and a rising ring-indicate level never sets the ring flag. Other behaviour can only be shown by the bench's scenarios. These are the exact synchronizer latency, the routing of each loop source to its line, the external pins being ignored in loop mode, and a read that coincides with a new transition.

// File: rtl/modem_hs_pkg.sv
// Shared definitions for the modem handshake monitor.
// Assumes line indices fix the bit order of the status byte.
package modem_hs_pkg;
    localparam int HS_LINES = 4;

    // Line index, also the bit position inside each status nibble
    typedef enum logic [1:0] {
        HS_CTS = 2'd0,
        HS_DSR = 2'd1,
        HS_RI  = 2'd2,
        HS_DCD = 2'd3
    } hs_line_e;

    // Which transitions a change flag records
    typedef enum logic {
        EDGE_ANY  = 1'b0,
        EDGE_FALL = 1'b1
    } edge_mode_e;
endpackage

// File: rtl/hs_sync.sv
// Multi-bit, multi-stage flop synchronizer.
// Assumes each bit is an independent slow level; no bus coherence implied.
module hs_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    // Shift the sampled levels down the chain each cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d_i;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/hs_delta_flag.sv
// Edge detector with a sticky flag for one synchronized line.
// Assumes level_i is already synchronous. A new event wins over a clear.
module hs_delta_flag
    import modem_hs_pkg::*;
#(
    parameter edge_mode_e MODE = EDGE_ANY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic clear_i,
    output logic flag_o
);
    logic prev_q;
    logic evt;

    generate
        if (MODE == EDGE_FALL) begin : g_fall
            assign evt = prev_q & ~level_i;
        end else begin : g_any
            assign evt = prev_q ^ level_i;
        end
    endgenerate

    // Remember the last level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    // Sticky flag: set by event, cleared by read, event has priority
    always_ff @(posedge clk) begin
        if (!rst_n) flag_o <= 1'b0;
        else        flag_o <= (flag_o & ~clear_i) | evt;
    end
endmodule

// File: rtl/modem_hs_ctrl.sv
// Modem handshake monitor top: output pins, loop routing, synchronizers,
// per-line change flags, status byte and interrupt.
// Assumes active-high handshake signals and a one-cycle read strobe.
module modem_hs_ctrl
    import modem_hs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    localparam int STAT_W     = 2 * HS_LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_dtr,
    input  logic              ctl_rts,
    input  logic              ctl_aux1,
    input  logic              ctl_aux2,
    input  logic              ctl_loop,
    input  logic              irq_en,
    input  logic              stat_rd,
    input  logic              pin_cts_i,
    input  logic              pin_dsr_i,
    input  logic              pin_dcd_i,
    input  logic              pin_ri_i,
    output logic              pin_dtr_o,
    output logic              pin_rts_o,
    output logic [STAT_W-1:0] stat_o,
    output logic              irq_o
);
    logic [HS_LINES-1:0] ext_lines;
    logic [HS_LINES-1:0] loop_lines;
    logic [HS_LINES-1:0] raw_lines;
    logic [HS_LINES-1:0] lvl;
    logic [HS_LINES-1:0] flags;

    // Gather external and looped sources in status-bit order
    always_comb begin
        ext_lines          = '0;
        loop_lines         = '0;
        ext_lines[HS_CTS]  = pin_cts_i;
        ext_lines[HS_DSR]  = pin_dsr_i;
        ext_lines[HS_RI]   = pin_ri_i;
        ext_lines[HS_DCD]  = pin_dcd_i;
        loop_lines[HS_CTS] = ctl_rts;
        loop_lines[HS_DSR] = ctl_dtr;
        loop_lines[HS_RI]  = ctl_aux1;
        loop_lines[HS_DCD] = ctl_aux2;
    end

    // Pick the line source; loop mode ignores the pins
    assign raw_lines = ctl_loop ? loop_lines : ext_lines;

    // Output pins are held inactive during self-test
    assign pin_dtr_o = ctl_dtr & ~ctl_loop;
    assign pin_rts_o = ctl_rts & ~ctl_loop;

    hs_sync #(
        .WIDTH  (HS_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_lines),
        .q_o   (lvl)
    );

    // One change flag per line; ring-indicate uses trailing edge only
    generate
        for (genvar i = 0; i < HS_LINES; i++) begin : g_line
            localparam edge_mode_e LMODE = (i == int'(HS_RI)) ? EDGE_FALL : EDGE_ANY;
            hs_delta_flag #(
                .MODE (LMODE)
            ) u_flag (
                .clk     (clk),
                .rst_n   (rst_n),
                .level_i (lvl[i]),
                .clear_i (stat_rd),
                .flag_o  (flags[i])
            );
        end
    endgenerate

    // Status byte and interrupt request
    assign stat_o = {lvl, flags};
    assign irq_o  = irq_en & (|flags);
endmodule

// File: rtl/modem_hs_checker.sv
// Cycle-level properties of the modem handshake monitor, bound to its ports.
module modem_hs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_dtr,
    input logic       ctl_rts,
    input logic       ctl_loop,
    input logic       irq_en,
    input logic       stat_rd,
    input logic       pin_dtr_o,
    input logic       pin_rts_o,
    input logic [7:0] stat_o,
    input logic       irq_o
);
    a_r9_irq_matches_flags: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (irq_en && (stat_o[3:0] != 4'h0)));

    a_r3_loop_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_loop |-> (!pin_dtr_o && !pin_rts_o));

    a_r2_pins_follow_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_loop |-> (pin_dtr_o == ctl_dtr && pin_rts_o == ctl_rts));

    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[0] && !stat_rd) |=> stat_o[0]);

    a_r5_cts_rise_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_o[4]) |=> stat_o[0]);

    a_r5_cts_fall_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_o[4]) |=> stat_o[0]);

    a_r6_ri_rise_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stat_o[6]) && !stat_o[2]) |=> !stat_o[2]);
endmodule

bind modem_hs_ctrl modem_hs_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_dtr   (ctl_dtr),
    .ctl_rts   (ctl_rts),
    .ctl_loop  (ctl_loop),
    .irq_en    (irq_en),
    .stat_rd   (stat_rd),
    .pin_dtr_o (pin_dtr_o),
    .pin_rts_o (pin_rts_o),
    .stat_o    (stat_o),
    .irq_o     (irq_o)
);

// File: tb/modem_hs_ctrl_bench.sv
module modem_hs_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 9;

    // Vector: [16] loop, [15:12] {dtr,rts,aux1,aux2}, [11:8] {cts,dsr,dcd,ri} pins, [7:0] expected status
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 4'b0000, 4'b1000, 8'h11},
        {1'b0, 4'b0000, 4'b1101, 8'h72},
        {1'b0, 4'b0000, 4'b0100, 8'h25},
        {1'b0, 4'b0000, 4'b0110, 8'hA8},
        {1'b0, 4'b0000, 4'b0110, 8'hA0},
        {1'b1, 4'b0100, 4'b0110, 8'h1B},
        {1'b1, 4'b1111, 4'b0000, 8'hFA},
        {1'b1, 4'b1001, 4'b0000, 8'hA5},
        {1'b0, 4'b1100, 4'b0000, 8'h0A}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_dtr = 1'b0, ctl_rts = 1'b0, ctl_aux1 = 1'b0, ctl_aux2 = 1'b0;
    logic ctl_loop = 1'b0, irq_en = 1'b0, stat_rd = 1'b0;
    logic pin_cts_i = 1'b0, pin_dsr_i = 1'b0, pin_dcd_i = 1'b0, pin_ri_i = 1'b0;
    logic pin_dtr_o, pin_rts_o, irq_o;
    logic [7:0] stat_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    modem_hs_ctrl u_modem_hs_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ctl_dtr(ctl_dtr), .ctl_rts(ctl_rts), .ctl_aux1(ctl_aux1), .ctl_aux2(ctl_aux2),
        .ctl_loop(ctl_loop), .irq_en(irq_en), .stat_rd(stat_rd),
        .pin_cts_i(pin_cts_i), .pin_dsr_i(pin_dsr_i), .pin_dcd_i(pin_dcd_i), .pin_ri_i(pin_ri_i),
        .pin_dtr_o(pin_dtr_o), .pin_rts_o(pin_rts_o), .stat_o(stat_o), .irq_o(irq_o)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_read();
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) stat_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: reset state
        chk("R1 status", stat_o, 8'h00);
        chk("R1 irq", {7'b0, irq_o}, 8'h00);
        irq_en = 1'b1;

        // Table walk: R2 R3 R4 R5 R6 R7 R9 R10
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            ctl_loop  = VEC[v][16];
            ctl_dtr   = VEC[v][15];
            ctl_rts   = VEC[v][14];
            ctl_aux1  = VEC[v][13];
            ctl_aux2  = VEC[v][12];
            pin_cts_i = VEC[v][11];
            pin_dsr_i = VEC[v][10];
            pin_dcd_i = VEC[v][9];
            pin_ri_i  = VEC[v][8];
            repeat (4) @(posedge clk);
            @(negedge clk);
            chk("R4/R5/R6/R10 status", stat_o, VEC[v][7:0]);
            chk("R9 irq", {7'b0, irq_o}, {7'b0, VEC[v][3:0] != 4'h0});
            if (VEC[v][16])
                chk("R3 pins", {6'b0, pin_dtr_o, pin_rts_o}, 8'h00);
            else
                chk("R2 pins", {6'b0, pin_dtr_o, pin_rts_o}, {6'b0, VEC[v][15], VEC[v][14]});
            do_read();
            chk("R7 cleared", stat_o, VEC[v][7:0] & 8'hF0);
        end

        // R9: enable gating; R11: flag holds without read
        irq_en = 1'b0;
        pin_cts_i = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R9 irq gated", {7'b0, irq_o}, 8'h00);
        chk("R5 cts flag", stat_o, 8'h11);
        irq_en = 1'b1;
        #1;
        chk("R9 irq enabled", {7'b0, irq_o}, 8'h01);
        repeat (10) @(negedge clk);
        chk("R11 sticky", stat_o, 8'h11);
        do_read();
        chk("R7 cleared", stat_o, 8'h10);

        // R4 latency and R8 read colliding with a new event
        pin_dsr_i = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R5 dsr flag", stat_o, 8'h32);
        pin_cts_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R4 one edge", stat_o, 8'h32);
        @(posedge clk);
        @(negedge clk);
        chk("R4 two edges", stat_o, 8'h22);
        stat_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        stat_rd = 1'b0;
        chk("R8 event wins", stat_o, 8'h21);
        chk("R9 irq", {7'b0, irq_o}, 8'h01);

        finish_run();
    end
endmodule